// File: doc/BRIEF.md
# Three-Level Virtual Address Translator

This block turns a 64-bit virtual address into a physical address by walking a tree of page tables held in memory. The tree is three levels deep. Every table occupies one 8 KB page of 1024 eight-byte entries. A request carries the address, an access kind (read, write or execute) and a flag that marks user mode. A page-table base input gives the physical page number of the top-level table. The block fetches one entry per level through a simple 64-bit read port. Each fetch is a one-cycle request strobe, answered by a read-valid strobe that may come any number of cycles later.

Before any fetch, the block checks the address. The bits above the 43-bit translated range must all be equal. The two top bits of that range then pick the region: the user region, a kernel region that maps straight to physical memory, or a kernel region that is translated. Kernel regions reject user-mode accesses. The result is a physical address and a two-bit fault code: none, page fault, protection violation or malformed address. A one-cycle done pulse marks the result, and the result stays on the outputs until the next request is accepted. The block offers no storage of past translations. Servicing of faults is left to the surrounding system.

Top module: `vxlat_walker`

## Requirements
- R1: While reset is held and just after it, reqReady is 1, done is 0, memReqValid is 0, faultCode is 0 and paOut is 0.
- R2: If reqVa bits 63..43 are not all equal, the result is faultCode 3 (malformed) and no memory read is issued. done rises in the second cycle after acceptance.
- R3: The direct-physical region is reqVa[42:41] = 2'b10. A kernel-mode access there (reqUser = 0) returns faultCode 0 and paOut = reqVa[40:0] zero-extended, with no memory read. done rises in the second cycle after acceptance.
- R4: A user-mode access (reqUser = 1) with reqVa[42] = 1, in either kernel region, returns faultCode 2 (protection) with no memory read. This check comes after the R2 check.
- R5: The level-1 entry address is {ptBase, 13'b0} + reqVa[42:33]*8. The level-2 entry address is {ppn1, 13'b0} + reqVa[32:23]*8, and the level-3 entry address is {ppn2, 13'b0} + reqVa[22:13]*8. Here ppnN is bits 63..32 of the entry fetched at level N.
- R6: Each fetch is a memReqValid pulse exactly one cycle long. The next fetch is issued in the cycle after the previous entry's memRdValid is sampled. A walk issues at most three fetches.
- R7: An entry with bit 0 (valid) equal to 0, at any level, ends the walk with faultCode 1 (page fault) and issues no further fetch.
- R8: The level-3 entry grants rights through bit 1 (read), bit 2 (write) and bit 3 (execute). reqAccess encodes 0 = read, 1 = write, 2 = execute; code 3 is never granted. An access without its right returns faultCode 2.
- R9: A walk that succeeds returns faultCode 0 and paOut = {level-3 bits 63..32, reqVa[12:0]}.
- R10: done is high for exactly one cycle per request. paOut and faultCode keep their values until the next request is accepted, and paOut is 0 whenever faultCode is nonzero.
- R11: reqReady is low from the cycle after acceptance through the done cycle. A reqValid during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | High when a request can be accepted |
| reqVa | input | 64 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqUser | input | 1 | 1 for a user-mode access |
| ptBase | input | 32 | Physical page number of the level-1 table |
| memReqValid | output | 1 | One-cycle fetch request |
| memAddr | output | 45 | Physical byte address of the entry to fetch |
| memRdValid | input | 1 | Fetched entry is on memRdData |
| memRdData | input | 64 | Fetched page table entry |
| done | output | 1 | One-cycle result pulse |
| paOut | output | 45 | Physical address result |
| faultCode | output | 2 | 0 none, 1 page, 2 protection, 3 malformed |

## Verification
The address checks, the region checks and the direct-physical path finish without a fetch, so their done pulse is due one cycle after acceptance. A walk adds one cycle plus the memory latency for each level it reads. The bench therefore predicts the done cycle as 1 + reads × (1 + latency), using a reference walk over its own table store. On every falling edge from acceptance onward, it compares done and reqReady against that count. It checks paOut and faultCode in the predicted done cycle and again after a pause. Every fetch address is matched against the queue of entry addresses that the reference walk produced.

// File: rtl/vxlat_pkg.sv
package vxlat_pkg;
  localparam int VA_W     = 64;
  localparam int IDX_W    = 10;
  localparam int OFF_W    = 13;
  localparam int LEVELS   = 3;
  localparam int PPN_W    = 32;
  localparam int PTE_W    = 64;
  localparam int PTE_LOG  = 3;
  localparam int TRANS_W  = OFF_W + LEVELS * IDX_W;
  localparam int PA_W     = PPN_W + OFF_W;
  localparam int BYPASS_W = TRANS_W - 2;
  localparam int PTE_FLAGS = 4;

  localparam int BIT_VALID = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_WR    = 2;
  localparam int BIT_EX    = 3;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_LVL1, ST_LVL2, ST_LVL3, ST_DONE, ST_FAULT
  } walkState_t;

  typedef enum logic [1:0] {
    FLT_NONE, FLT_PAGE, FLT_PROT, FLT_MALFORMED
  } fault_t;

  typedef struct packed {
    logic       loadReq;
    logic       issue;
    logic [1:0] issueLvl;
    logic       finOk;
    logic       bypass;
    logic       finFault;
    fault_t     faultCode;
  } walkCtl_t;

  typedef struct packed {
    logic badAddr;
    logic userKernel;
    logic physRegion;
    logic entryValid;
    logic rightsOk;
  } walkStat_t;
endpackage

// File: rtl/vxlat_dpath.sv
module vxlat_dpath
  import vxlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  walkCtl_t         ctl,
  output walkStat_t        stat,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqAccess,
  input  logic             reqUser,
  input  logic [PPN_W-1:0] ptBase,
  input  logic [PTE_W-1:0] memRdData,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memAddr,
  output logic [PA_W-1:0]  paOut,
  output fault_t           faultOut
);
  logic [VA_W-1:0]  vaQ;
  logic [1:0]       accQ;
  logic             userQ;
  logic [IDX_W-1:0] lvlIdx [LEVELS];
  logic [IDX_W-1:0] selIdx;
  logic [PPN_W-1:0] nextBase;
  logic [PA_W-1:0]  entryAddr;
  logic [VA_W-TRANS_W-1:0] upperBits;
  logic [1:0]       regionBits;
  logic [PPN_W-1:0] entryPpn;
  logic             unusedPteBits;

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : gIdx
      assign lvlIdx[g] = vaQ[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
    end
  endgenerate

  assign upperBits  = vaQ[VA_W-1:TRANS_W];
  assign regionBits = vaQ[TRANS_W-1 -: 2];
  assign entryPpn   = memRdData[PTE_W-1 -: PPN_W];
  assign unusedPteBits = ^memRdData[PTE_W-PPN_W-1:PTE_FLAGS];

  always_comb begin
    stat.badAddr    = !((&upperBits) || (~|upperBits));
    stat.userKernel = userQ && regionBits[1];
    stat.physRegion = (regionBits == 2'b10);
    stat.entryValid = memRdData[BIT_VALID];
    case (accQ)
      ACC_READ:  stat.rightsOk = memRdData[BIT_RD];
      ACC_WRITE: stat.rightsOk = memRdData[BIT_WR];
      ACC_EXEC:  stat.rightsOk = memRdData[BIT_EX];
      default:   stat.rightsOk = 1'b0;
    endcase
  end

  always_comb begin
    selIdx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (ctl.issueLvl == 2'(i)) selIdx = lvlIdx[i];
    end
  end

  assign nextBase  = (ctl.issueLvl == 2'd0) ? ptBase : entryPpn;
  assign entryAddr = {nextBase, {OFF_W{1'b0}}}
                   + {{(PA_W-IDX_W-PTE_LOG){1'b0}}, selIdx, {PTE_LOG{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ         <= '0;
      accQ        <= '0;
      userQ       <= 1'b0;
      memReqValid <= 1'b0;
      memAddr     <= '0;
      paOut       <= '0;
      faultOut    <= FLT_NONE;
    end else begin
      memReqValid <= ctl.issue;
      if (ctl.issue) memAddr <= entryAddr;
      if (ctl.loadReq) begin
        vaQ      <= reqVa;
        accQ     <= reqAccess;
        userQ    <= reqUser;
        paOut    <= '0;
        faultOut <= FLT_NONE;
      end else if (ctl.finOk) begin
        faultOut <= FLT_NONE;
        if (ctl.bypass) paOut <= {{(PA_W-BYPASS_W){1'b0}}, vaQ[BYPASS_W-1:0]};
        else            paOut <= {entryPpn, vaQ[OFF_W-1:0]};
      end else if (ctl.finFault) begin
        faultOut <= ctl.faultCode;
        paOut    <= '0;
      end
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadReq && !ctl.finOk && !ctl.finFault) |=> ($stable(paOut) && $stable(faultOut))); // R10
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (faultOut != FLT_NONE) |-> (paOut == '0)); // R10
endmodule

// File: rtl/vxlat_ctrl.sv
module vxlat_ctrl
  import vxlat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memRdValid,
  input  walkStat_t stat,
  output walkCtl_t  ctl,
  output logic      reqReady,
  output logic      done
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = walkCtl_t'('0);
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        ctl.loadReq = 1'b1;
        nextState   = ST_CHECK;
      end
      ST_CHECK: begin
        if (stat.badAddr) begin
          ctl.finFault  = 1'b1;
          ctl.faultCode = FLT_MALFORMED;
          nextState     = ST_FAULT;
        end else if (stat.userKernel) begin
          ctl.finFault  = 1'b1;
          ctl.faultCode = FLT_PROT;
          nextState     = ST_FAULT;
        end else if (stat.physRegion) begin
          ctl.finOk  = 1'b1;
          ctl.bypass = 1'b1;
          nextState  = ST_DONE;
        end else begin
          ctl.issue    = 1'b1;
          ctl.issueLvl = 2'd0;
          nextState    = ST_LVL1;
        end
      end
      ST_LVL1, ST_LVL2: if (memRdValid) begin
        if (!stat.entryValid) begin
          ctl.finFault  = 1'b1;
          ctl.faultCode = FLT_PAGE;
          nextState     = ST_FAULT;
        end else begin
          ctl.issue    = 1'b1;
          ctl.issueLvl = (state == ST_LVL1) ? 2'd1 : 2'd2;
          nextState    = (state == ST_LVL1) ? ST_LVL2 : ST_LVL3;
        end
      end
      ST_LVL3: if (memRdValid) begin
        if (!stat.entryValid) begin
          ctl.finFault  = 1'b1;
          ctl.faultCode = FLT_PAGE;
          nextState     = ST_FAULT;
        end else if (!stat.rightsOk) begin
          ctl.finFault  = 1'b1;
          ctl.faultCode = FLT_PROT;
          nextState     = ST_FAULT;
        end else begin
          ctl.finOk = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_DONE, ST_FAULT: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_DONE) || (state == ST_FAULT);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady); // R11
  AST_BAD_NO_WALK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && stat.badAddr) |=> (state == ST_FAULT)); // R2
endmodule

// File: rtl/vxlat_walker.sv
module vxlat_walker
  import vxlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqAccess,
  input  logic             reqUser,
  input  logic [PPN_W-1:0] ptBase,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memAddr,
  input  logic             memRdValid,
  input  logic [PTE_W-1:0] memRdData,
  output logic             done,
  output logic [PA_W-1:0]  paOut,
  output logic [1:0]       faultCode
);
  walkCtl_t  ctl;
  walkStat_t stat;
  fault_t    faultOut;

  vxlat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRdValid(memRdValid),
    .stat(stat), .ctl(ctl), .reqReady(reqReady), .done(done)
  );

  vxlat_dpath uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat), .reqVa(reqVa),
    .reqAccess(reqAccess), .reqUser(reqUser), .ptBase(ptBase),
    .memRdData(memRdData), .memReqValid(memReqValid), .memAddr(memAddr),
    .paOut(paOut), .faultOut(faultOut)
  );

  assign faultCode = faultOut;

  AST_FETCH_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R11
endmodule

// File: tb/vxlat_walker_test.sv
module vxlat_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic [31:0] ptBase = 32'h100;
  logic        memReqValid;
  logic [44:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [63:0] memRdData = '0;
  logic        done;
  logic [44:0] paOut;
  logic [1:0]  faultCode;

  vxlat_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqAccess(reqAccess), .reqUser(reqUser), .ptBase(ptBase),
    .memReqValid(memReqValid), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .done(done), .paOut(paOut), .faultCode(faultCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [63:0] mem [longint];
  longint expAddrQ [$];
  longint pendAddr = 0;
  int pendCnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic logic [63:0] pte(input logic [31:0] ppn, input logic [3:0] flags);
    return {ppn, 28'h0, flags};
  endfunction

  function automatic longint entAddr(input longint ppn, input longint idx);
    return (ppn << 13) + idx * 8;
  endfunction

  function automatic logic [63:0] rdMem(input longint a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  // Behavioural reference walk; pushes expected fetch addresses.
  task automatic refWalk(input logic [63:0] va, input logic [1:0] acc, input bit usr,
                         output logic [1:0] f, output logic [44:0] pa, output int reads);
    logic [63:0] e;
    longint base;
    bit ok;
    f = 2'd0; pa = '0; reads = 0;
    if (!(va[63:43] == '0 || va[63:43] == '1)) begin f = 2'd3; return; end
    if (usr && va[42]) begin f = 2'd2; return; end
    if (va[42:41] == 2'b10) begin pa = {4'h0, va[40:0]}; return; end
    base = longint'(ptBase);
    e = '0;
    for (int lvl = 0; lvl < 3; lvl++) begin
      longint idx;
      idx = longint'((va >> (13 + 10 * (2 - lvl))) & 64'h3FF);
      expAddrQ.push_back(entAddr(base, idx));
      reads++;
      e = rdMem(entAddr(base, idx));
      if (!e[0]) begin f = 2'd1; return; end
      base = longint'(e[63:32]);
    end
    ok = (acc == 2'd0) ? e[1] : (acc == 2'd1) ? e[2] : (acc == 2'd2) ? e[3] : 1'b0;
    if (!ok) begin f = 2'd2; return; end
    pa = {e[63:32], va[12:0]};
  endtask

  // Memory model: answers each fetch MEM_LAT falling edges after seeing it.
  always @(negedge clk) begin : memModel
    longint ea;
    memRdValid <= 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRdValid <= 1'b1;
        memRdData  <= rdMem(pendAddr);
      end
    end
    if (rstN && memReqValid) begin
      if (expAddrQ.size() == 0) begin
        chk(0, "R6 unexpected fetch", 64'(memAddr), 64'h0);
      end else begin
        ea = expAddrQ.pop_front();
        chk(64'(memAddr) == 64'(ea), "R5 entry address", 64'(memAddr), 64'(ea));
      end
      pendAddr = longint'(memAddr);
      pendCnt  = MEM_LAT;
    end
  end

  task automatic runReq(input logic [63:0] va, input logic [1:0] acc, input bit usr,
                        input logic [1:0] expF, input bit poke, input string tag);
    logic [1:0] rf;
    logic [44:0] rpa;
    int reads;
    int lat;
    expAddrQ.delete();
    refWalk(va, acc, usr, rf, rpa, reads);
    chk(rf == expF, {tag, " reference fault"}, 64'(rf), 64'(expF));
    lat = (reads == 0) ? 1 : 1 + reads * (1 + MEM_LAT);
    @(negedge clk);
    chk(reqReady == 1'b1, "R11 ready before request", 64'(reqReady), 64'h1);
    reqValid = 1'b1; reqVa = va; reqAccess = acc; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n <= lat + 1; n++) begin
      if (n > 0) @(negedge clk);
      if (poke && n == 1) begin reqValid = 1'b1; reqVa = ~va; reqAccess = 2'd0; end
      if (poke && n == 3) reqValid = 1'b0;
      chk(done == (n == lat), "R10 done timing", 64'(done), 64'(n == lat));
      chk(reqReady == (n > lat), "R11 ready timing", 64'(reqReady), 64'(n > lat));
      if (n == lat) begin
        chk(faultCode == expF, {tag, " fault code"}, 64'(faultCode), 64'(expF));
        chk(paOut == rpa, {tag, " physical address"}, 64'(paOut), 64'(rpa));
      end
    end
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && faultCode == expF && paOut == rpa, "R10 result held",
        {17'h0, done, faultCode, paOut}, {17'h0, 1'b0, expF, rpa});
    chk(expAddrQ.size() == 0, "R6 all fetches issued", 64'(expAddrQ.size()), 64'h0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    finishRun();
  end

  localparam logic [63:0] VA_USER = 64'h0000_0001_2000_0456;
  localparam logic [63:0] VA_KVIRT = 64'hFFFF_FE00_0000_0010;
  localparam logic [63:0] VA_KPHYS = 64'hFFFF_FC00_1234_5678;

  initial begin : stimulus
    mem[entAddr(64'h100, 0)]   = pte(32'h200, 4'b0001);
    mem[entAddr(64'h200, 576)] = pte(32'h300, 4'b0001);
    mem[entAddr(64'h300, 0)]   = pte(32'h12345, 4'b0011);
    mem[entAddr(64'h300, 1)]   = pte(32'h02222, 4'b0111);
    mem[entAddr(64'h300, 2)]   = pte(32'h03333, 4'b1001);
    mem[entAddr(64'h100, 768)] = pte(32'h201, 4'b0001);
    mem[entAddr(64'h201, 0)]   = pte(32'h301, 4'b0001);
    mem[entAddr(64'h301, 0)]   = pte(32'hABCDE, 4'b0011);

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1 && done == 1'b0 && memReqValid == 1'b0, "R1 reset handshake",
        {61'h0, reqReady, done, memReqValid}, 64'h4);
    chk(faultCode == 2'd0 && paOut == '0, "R1 reset result", {17'h0, faultCode, paOut}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && done == 1'b0, "R1 after reset", {62'h0, reqReady, done}, 64'h2);

    runReq(VA_USER, 2'd0, 1'b1, 2'd0, 1'b0, "R9 user read walk");
    runReq(VA_USER, 2'd1, 1'b1, 2'd2, 1'b0, "R8 write to read-only page");
    runReq(VA_USER + 64'h2000, 2'd1, 1'b1, 2'd0, 1'b0, "R8 write allowed");
    runReq(VA_USER + 64'h4000, 2'd2, 1'b0, 2'd0, 1'b0, "R8 execute allowed");
    runReq(VA_USER + 64'h4000, 2'd0, 1'b1, 2'd2, 1'b0, "R8 read on execute-only");
    runReq(VA_USER + 64'h2000, 2'd3, 1'b0, 2'd2, 1'b0, "R8 access code 3");
    runReq(VA_USER + 64'h6000, 2'd0, 1'b1, 2'd1, 1'b0, "R7 invalid level-3 entry");
    runReq(VA_USER + 64'h80_0000, 2'd0, 1'b1, 2'd1, 1'b0, "R7 invalid level-2 entry");
    runReq(64'h0000_0002_0000_0000, 2'd0, 1'b1, 2'd1, 1'b0, "R7 invalid level-1 entry");
    runReq(64'h0001_0000_0000_0000, 2'd0, 1'b0, 2'd3, 1'b0, "R2 malformed high bit");
    runReq(64'h8000_0000_0000_0000, 2'd0, 1'b0, 2'd3, 1'b0, "R2 malformed top bit");
    runReq(VA_KPHYS, 2'd0, 1'b0, 2'd0, 1'b0, "R3 direct-physical region");
    runReq(VA_KPHYS, 2'd0, 1'b1, 2'd2, 1'b0, "R4 user in physical region");
    runReq(VA_KVIRT, 2'd0, 1'b1, 2'd2, 1'b0, "R4 user in kernel virtual region");
    runReq(VA_KVIRT, 2'd0, 1'b0, 2'd0, 1'b0, "R5 kernel virtual walk");
    runReq(VA_USER, 2'd0, 1'b1, 2'd0, 1'b1, "R11 request while busy");

    finishRun();
  end
endmodule